// File: doc/BRIEF.md
# Transmit status and interrupt manager

This block is the per-port status keeper of a network controller. When the transmitter finishes a packet, the block records the packet's status word in a small ordered store that holds two entries. It also keeps a sticky receive status word. Both are combined with host-programmed enable masks to drive a single active-high interrupt line for the port.

The host uses a four-address register port. Reading a status address returns that status and clears it, which is also the only way to clear the interrupt it raised. Two configuration bits set the store's policy. One bit stops successful packets from being recorded, so only failures take up slots. The other bit drops a transmit-permit output while both slots are occupied, so the transmitter cannot start a packet whose status would have nowhere to go.

Top module: `txstat_irq_mgr`

## Requirements
- R1: After reset, `irq` is 0, `tx_permit` is 1, `rdata` is 0, both configuration bits and both enable masks are 0, and the transmit store and the receive status are empty.
- R2: A `tx_done` pulse that is not skipped writes `tx_stat` into the store. Entries are held in arrival order. A read of address 2 (`rd_en` high with `addr`=2) returns the oldest entry on `rdata` after the clock edge that samples the read, and frees that entry.
- R3: While configuration bit 0 is 1, a `tx_done` with `tx_ok`=1 stores nothing. A `tx_done` with `tx_ok`=0 is still stored.
- R4: A read of address 2 while the store is empty returns 0 and changes nothing.
- R5: Each cycle, the bits of `rx_evt` are ORed into a sticky receive status. A read of address 3 returns that status and clears it. Event bits that arrive in the same cycle as that read are kept for the next read.
- R6: When both slots are full, a completion that arrives without a read of address 2 is dropped and the stored entries stay unchanged. A completion that arrives in the same cycle as such a read is stored as the newest entry.
- R7: While configuration bit 1 is 1 and both slots are full, `tx_permit` is 0 from one clock after that condition begins. It returns to 1 one clock after a slot frees up. While bit 1 is 0, `tx_permit` is 1.
- R8: `irq` is a register. It goes high one clock after either of these becomes nonzero: the receive status ANDed with the receive enable mask, or the OR of all stored transmit entries ANDed with the transmit enable mask. It goes low one clock after the status that caused it has been read away.
- R9: Register map. Address 0 holds the configuration: bit 0 skips successful packets and bit 1 holds transmission while the store is full. It reads back with the unused bits as 0. Address 1 holds the receive enable mask in bits [RX_W-1:0] and reads back. A write to address 2 sets the transmit enable mask. A write to address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done | input | 1 | One-cycle strobe at the end of a packet transmission |
| tx_ok | input | 1 | Packet completed without error; valid with `tx_done` |
| tx_stat | input | STAT_W | Completion status word; valid with `tx_done` |
| rx_evt | input | RX_W | Receive status bits to set this cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid after the edge that samples `rd_en` |
| irq | output | 1 | Merged interrupt, active high |
| tx_permit | output | 1 | High when a new transmission may start |

## Verification
A read or write pointer that is out of step shows up on the very next status read. Entries come back out of order, repeated, or as 0 while data is still held. A stuck valid flag shows up two ways. `tx_permit` stays low after a read that should free a slot. `irq` stays high one clock after the last status has been drained. A receive status that loses or keeps the wrong bits at a read shows up in the value returned by the next read of address 3, and in `irq` one clock later.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    A_CFG = 2'd0,
    A_IE  = 2'd1,
    A_TXS = 2'd2,
    A_RXS = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic hold_full;
    logic skip_ok;
  } cfg_t;
endpackage

// File: rtl/txs_cfg_regs.sv
module txs_cfg_regs
  import txs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 16,
  parameter int RX_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg,
  output logic [RX_W-1:0]   rx_ie,
  output logic [STAT_W-1:0] tx_ie
);
  reg_addr_e a;
  assign a = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      rx_ie <= '0;
      tx_ie <= '0;
    end else if (wr_en) begin
      case (a)
        A_CFG:   cfg   <= cfg_t'(wdata[1:0]);
        A_IE:    rx_ie <= wdata[RX_W-1:0];
        A_TXS:   tx_ie <= wdata[STAT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txs_tx_store.sv
module txs_tx_store #(
  parameter int STAT_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              push_ok,
  input  logic [STAT_W-1:0] push_data,
  input  logic              skip_ok,
  input  logic              pop_req,
  output logic [STAT_W-1:0] pop_data,
  output logic              full,
  output logic [STAT_W-1:0] any_bits
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [STAT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              empty, pop, push;
  logic [STAT_W-1:0] slot_bits [DEPTH];

  assign full  = &vld;
  assign empty = ~|vld;
  assign pop   = pop_req && !empty;
  assign push  = push_req && !(push_ok && skip_ok) && (!full || pop);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      pop_data <= '0;
    end else begin
      if (pop) begin
        pop_data    <= mem[rd_ptr];
        vld[rd_ptr] <= 1'b0;
        rd_ptr      <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end else if (pop_req) begin
        pop_data <= '0;
      end
      if (push) begin
        vld[wr_ptr] <= 1'b1;
        wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign slot_bits[i] = vld[i] ? mem[i] : '0;
  end

  always_comb begin
    any_bits = '0;
    for (int i = 0; i < DEPTH; i++) any_bits |= slot_bits[i];
  end

  // R3: a skipped successful completion leaves occupancy untouched
  a_r3_skip_keeps_store: assert property (@(posedge clk) disable iff (rst)
    (push_req && push_ok && skip_ok && !pop_req) |=> $stable(vld));
  // R6: full store without a read never advances the write side
  a_r6_full_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    (full && !pop_req) |=> ($stable(wr_ptr) && full));
  // R4: empty read yields zero and leaves the read side alone
  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty) |=> (pop_data == '0 && $stable(rd_ptr)));
endmodule

// File: rtl/txs_rx_status.sv
module txs_rx_status #(
  parameter int RX_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RX_W-1:0] evt,
  input  logic            clr,
  output logic [RX_W-1:0] stat
);
  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (clr ? '0 : stat) | evt;
  end

  // R5: a read with no new event leaves the status empty
  a_r5_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (clr && evt == '0) |=> (stat == '0));
  // R5: without a read no bit is ever lost
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/txstat_irq_mgr.sv
module txstat_irq_mgr
  import txs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 16,
  parameter int RX_W   = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_done,
  input  logic              tx_ok,
  input  logic [STAT_W-1:0] tx_stat,
  input  logic [RX_W-1:0]   rx_evt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              tx_permit
);
  cfg_t              cfg;
  logic [RX_W-1:0]   rx_ie, rx_stat;
  logic [STAT_W-1:0] tx_ie, tx_bits, tx_pop_data;
  logic              tx_full, rd_tx, rd_rx;
  logic              rx_cause, tx_cause;
  logic              sel_tx_q;
  logic [DATA_W-1:0] rdata_q;
  reg_addr_e         a;

  assign a        = reg_addr_e'(addr);
  assign rd_tx    = rd_en && (a == A_TXS);
  assign rd_rx    = rd_en && (a == A_RXS);
  assign rx_cause = |(rx_stat & rx_ie);
  assign tx_cause = |(tx_bits & tx_ie);

  txs_cfg_regs #(.DATA_W(DATA_W), .STAT_W(STAT_W), .RX_W(RX_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cfg(cfg), .rx_ie(rx_ie), .tx_ie(tx_ie)
  );

  txs_tx_store #(.STAT_W(STAT_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push_req(tx_done), .push_ok(tx_ok),
    .push_data(tx_stat), .skip_ok(cfg.skip_ok), .pop_req(rd_tx),
    .pop_data(tx_pop_data), .full(tx_full), .any_bits(tx_bits)
  );

  txs_rx_status #(.RX_W(RX_W)) u_rx (
    .clk(clk), .rst(rst), .evt(rx_evt), .clr(rd_rx), .stat(rx_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_tx_q  <= 1'b0;
      rdata_q   <= '0;
      irq       <= 1'b0;
      tx_permit <= 1'b1;
    end else begin
      if (rd_en) begin
        sel_tx_q <= (a == A_TXS);
        case (a)
          A_CFG:   rdata_q <= DATA_W'(cfg);
          A_IE:    rdata_q <= DATA_W'(rx_ie);
          A_RXS:   rdata_q <= DATA_W'(rx_stat);
          default: rdata_q <= '0;
        endcase
      end
      irq       <= rx_cause || tx_cause;
      tx_permit <= !(cfg.hold_full && tx_full);
    end
  end

  assign rdata = sel_tx_q ? DATA_W'(tx_pop_data) : rdata_q;

  // R7: permit is forced high while the hold bit is clear
  a_r7_permit_free: assert property (@(posedge clk) disable iff (rst)
    (!cfg.hold_full) |=> tx_permit);
  // R7: full store under hold drops the permit next cycle
  a_r7_permit_block: assert property (@(posedge clk) disable iff (rst)
    (cfg.hold_full && tx_full) |=> !tx_permit);
  // R8: interrupt only follows an enabled cause
  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rx_cause || tx_cause));
endmodule

// File: tb/tb_txstat_irq_mgr.sv
module tb_txstat_irq_mgr;
  localparam int DATA_W = 16, STAT_W = 16, RX_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tx_done = 1'b0, tx_ok = 1'b0;
  logic [STAT_W-1:0] tx_stat = '0;
  logic [RX_W-1:0]   rx_evt = '0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]        addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq, tx_permit;

  int n_cmp = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  txstat_irq_mgr #(.DATA_W(DATA_W), .STAT_W(STAT_W), .RX_W(RX_W)) dut (
    .clk(clk), .rst(rst), .tx_done(tx_done), .tx_ok(tx_ok), .tx_stat(tx_stat),
    .rx_evt(rx_evt), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .tx_permit(tx_permit)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic cmpl(logic ok, logic [STAT_W-1:0] s);
    @(negedge clk); tx_done = 1'b1; tx_ok = ok; tx_stat = s;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_permit", 32'(tx_permit), 1);
    chk("R1 rdata", 32'(rdata), 0);
    rd(2'd0, d); chk("R1 cfg", 32'(d), 0);
    rd(2'd1, d); chk("R1 rx_ie", 32'(d), 0);
    rd(2'd2, d); chk("R1 store empty", 32'(d), 0);
  endtask

  task automatic t_order();
    logic [DATA_W-1:0] d;
    wr(2'd2, 16'hFFFF);
    cmpl(1'b0, 16'h00A1); settle();
    chk("R8 irq on tx status", 32'(irq), 1);
    cmpl(1'b1, 16'h00B2);
    rd(2'd2, d); chk("R2 oldest first", 32'(d), 32'h00A1);
    rd(2'd2, d); chk("R2 second", 32'(d), 32'h00B2);
    settle();
    chk("R8 irq cleared by read", 32'(irq), 0);
    rd(2'd2, d); chk("R4 empty read", 32'(d), 0);
    cmpl(1'b0, 16'h0C0C);
    rd(2'd2, d); chk("R4 no side effect", 32'(d), 32'h0C0C);
  endtask

  task automatic t_skip();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'h0001);
    cmpl(1'b1, 16'h0055);
    rd(2'd2, d); chk("R3 success skipped", 32'(d), 0);
    cmpl(1'b0, 16'h0066);
    rd(2'd2, d); chk("R3 failure kept", 32'(d), 32'h0066);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_full_drop();
    logic [DATA_W-1:0] d;
    cmpl(1'b0, 16'h0001); cmpl(1'b0, 16'h0002); cmpl(1'b0, 16'h0003);
    rd(2'd2, d); chk("R6 keep first", 32'(d), 32'h0001);
    rd(2'd2, d); chk("R6 keep second", 32'(d), 32'h0002);
    rd(2'd2, d); chk("R6 third dropped", 32'(d), 0);
  endtask

  task automatic t_same_cycle();
    logic [DATA_W-1:0] d;
    cmpl(1'b0, 16'h0011); cmpl(1'b0, 16'h0022);
    @(negedge clk);
    rd_en = 1'b1; addr = 2'd2; tx_done = 1'b1; tx_ok = 1'b0; tx_stat = 16'h0033;
    @(negedge clk);
    rd_en = 1'b0; tx_done = 1'b0;
    chk("R6 read during refill", 32'(rdata), 32'h0011);
    rd(2'd2, d); chk("R6 middle", 32'(d), 32'h0022);
    rd(2'd2, d); chk("R6 refilled newest", 32'(d), 32'h0033);
  endtask

  task automatic t_hold();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'h0002);
    cmpl(1'b0, 16'h0101); settle();
    chk("R7 permit one slot", 32'(tx_permit), 1);
    cmpl(1'b0, 16'h0102); settle();
    chk("R7 permit low when full", 32'(tx_permit), 0);
    rd(2'd2, d); settle();
    chk("R7 permit after free", 32'(tx_permit), 1);
    cmpl(1'b0, 16'h0103); settle();
    chk("R7 low again", 32'(tx_permit), 0);
    wr(2'd0, 16'h0000); settle();
    chk("R7 hold bit clear", 32'(tx_permit), 1);
    rd(2'd2, d); rd(2'd2, d);
  endtask

  task automatic t_rx();
    logic [DATA_W-1:0] d;
    wr(2'd1, 16'h0001);
    @(negedge clk); rx_evt = 8'h02; @(negedge clk); rx_evt = 8'h00;
    settle();
    chk("R8 masked rx no irq", 32'(irq), 0);
    @(negedge clk); rx_evt = 8'h01; @(negedge clk); rx_evt = 8'h00;
    settle();
    chk("R8 enabled rx irq", 32'(irq), 1);
    rd(2'd3, d); chk("R5 sticky bits", 32'(d), 32'h03);
    settle();
    chk("R8 irq cleared", 32'(irq), 0);
    @(negedge clk); rd_en = 1'b1; addr = 2'd3; rx_evt = 8'h04;
    @(negedge clk); rd_en = 1'b0; rx_evt = 8'h00;
    chk("R5 read with event", 32'(rdata), 0);
    rd(2'd3, d); chk("R5 event kept", 32'(d), 32'h04);
    rd(2'd3, d); chk("R5 cleared", 32'(d), 0);
  endtask

  task automatic t_tx_mask();
    logic [DATA_W-1:0] d;
    wr(2'd2, 16'h00F0);
    cmpl(1'b0, 16'h000F); settle();
    chk("R8 masked tx no irq", 32'(irq), 0);
    rd(2'd2, d);
    cmpl(1'b0, 16'h0010); settle();
    chk("R8 enabled tx irq", 32'(irq), 1);
    rd(2'd2, d); settle();
    chk("R8 tx irq cleared", 32'(irq), 0);
  endtask

  task automatic t_regmap();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R9 cfg readback", 32'(d), 32'h0003);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hA5A5);
    rd(2'd1, d); chk("R9 rx_ie readback", 32'(d), 32'h00A5);
    wr(2'd3, 16'h00FF);
    rd(2'd3, d); chk("R9 write to rx status ignored", 32'(d), 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_skip();
    t_full_drop();
    t_same_cycle();
    t_hold();
    t_rx();
    t_tx_mask();
    t_regmap();
    summary();
    $finish;
  end
endmodule